// File: doc/BRIEF.md
# DMA timeout expiry classifier

This block supervises one bus-master DMA command at a time. Issuing a command (`start`) arms a countdown of twice the programmed base wait. When the transfer completes first (`done`), the watch ends quietly. When the countdown runs out, the block reads the DMA status byte and gives a verdict on a one-cycle strobe. The verdict is one of three: keep waiting (the counter is re-armed for one base wait), fail the command, or request a bus reset.

Each command gets exactly one reprieve. The first expiry uses it up, and any later expiry of the same command is a hard failure. There is one exception. When the two status bits that mark a timer that fired too early are both set, the counter is re-armed and the reprieve is kept. Retry policy and fallback to programmed I/O belong to the surrounding controller.

Top module: `dma_expiry_watch`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) ends any watch, drives `outcome_valid`, `error_pulse` and `reset_pulse` low with `outcome_code` 00, and restores the reprieve; no outcome follows until a new `start`.
- R2: After the edge that samples `start`, the first expiry strobe `outcome_valid` appears high for one cycle after the 2×`base_wait`-th following rising edge, with the status byte sampled at that edge.
- R3: `outcome_code` is 01 for wait, 10 for fail, 11 for bus reset and 00 whenever no strobe is present. While the reprieve is available and the early-timer pattern is absent, the status bits are checked in this order. Status bit 1 (error) gives fail. Otherwise bit 0 (transfer active) gives wait. Otherwise bit 2 (interrupt pending) gives wait. Otherwise the result is bus reset.
- R4: Any non-early expiry while the reprieve is available uses it up. Once it is spent, the next expiry gives fail whatever the status byte holds.
- R5: While the reprieve is available, status bits 4 and 3 both set give wait and leave the reprieve unused. This takes precedence over the error bit.
- R6: A wait verdict re-arms the counter, so the next expiry strobe appears `base_wait` rising edges after the edge that produced the wait.
- R7: `done` sampled at an edge before the expiry edge, or at the expiry edge itself, ends the watch with no strobe and no pulse.
- R8: `start` sampled during a watch restarts it with a 2×`base_wait` countdown and a restored reprieve, and suppresses any verdict at that edge.
- R9: `error_pulse` is high exactly in the cycles that carry a fail strobe, and `reset_pulse` exactly in those carrying a bus-reset strobe. The two are never high together.
- R10: A `base_wait` of zero is treated as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Command issued: arm the watch |
| done | input | 1 | Transfer completed: end the watch silently |
| status | input | STAT_W | DMA status byte sampled at expiry |
| base_wait | input | WAIT_W | Base wait period in clock cycles |
| outcome_valid | output | 1 | One-cycle verdict strobe |
| outcome_code | output | 2 | Verdict: 01 wait, 10 fail, 11 bus reset, 00 none |
| error_pulse | output | 1 | One-cycle fail indication |
| reset_pulse | output | 1 | One-cycle bus-reset request |

## Verification
The sharpest collision is completion against expiry. The bench raises `done` for exactly the cycle whose closing edge would otherwise produce the first verdict. It then watches several base periods for silence, since completion must win. A second collision sets `start` against a running watch: re-issuing mid-count must push the next verdict a full doubled period out and bring back the reprieve. This is judged by a wait verdict followed by a fail one base period later.

// File: rtl/dmaexp_pkg.sv
package dmaexp_pkg;

   typedef enum logic [1:0] {
      OC_IDLE  = 2'd0,
      OC_WAIT  = 2'd1,
      OC_FAIL  = 2'd2,
      OC_RESET = 2'd3
   } outcome_e;

   // status bit positions decoded at expiry
   localparam int ST_ACTIVE   = 0;
   localparam int ST_ERROR    = 1;
   localparam int ST_IRQ      = 2;
   localparam int ST_EARLY_LO = 3;
   localparam int ST_EARLY_HI = 4;
   localparam int ST_MIN_W    = ST_EARLY_HI + 1;

   typedef struct packed {
      outcome_e code;
      logic     rearm;
      logic     consume;
   } verdict_t;

endpackage

// File: rtl/dmaexp_timer.sv
module dmaexp_timer #(
   parameter int CW       = 17,
   parameter int COUNT_UP = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          clear,
   output logic          expire
);

   localparam logic [CW-1:0] ONE = CW'(1);

   if (CW < 2) begin : g_bad_cw
      $error("dmaexp_timer: CW must be at least 2");
   end

   if (COUNT_UP != 0) begin : g_up
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] lim_q;
      logic          act_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_q <= '0;
            lim_q <= '0;
            act_q <= 1'b0;
         end else if (load) begin
            cnt_q <= '0;
            lim_q <= load_val;
            act_q <= 1'b1;
         end else if (clear) begin
            act_q <= 1'b0;
         end else if (act_q) begin
            cnt_q <= cnt_q + ONE;
            if ((cnt_q + ONE) == lim_q) act_q <= 1'b0;
         end
      end

      assign expire = act_q && (cnt_q == (lim_q - ONE));
   end else begin : g_down
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_q <= '0;
         end else if (load) begin
            cnt_q <= load_val;
         end else if (clear) begin
            cnt_q <= '0;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
         end
      end

      assign expire = (cnt_q == ONE);
   end

   // R7: a clear without a load leaves no expiry behind
   a_r7_clear_silences: assert property (@(posedge clk) disable iff (rst)
      (clear && !load) |=> !expire);

endmodule

// File: rtl/dmaexp_classify.sv
module dmaexp_classify
   import dmaexp_pkg::*;
#(
   parameter int STAT_W = 8
) (
   input  logic [STAT_W-1:0] status,
   input  logic              reprieve,
   output verdict_t          verdict
);

   if (STAT_W < ST_MIN_W) begin : g_bad_w
      $error("dmaexp_classify: STAT_W too narrow for decoded bits");
   end

   logic early;
   assign early = status[ST_EARLY_HI] & status[ST_EARLY_LO];

   always_comb begin
      verdict = '{code: OC_FAIL, rearm: 1'b0, consume: 1'b0};
      if (!reprieve) begin
         verdict = '{code: OC_FAIL, rearm: 1'b0, consume: 1'b0};
      end else if (early) begin
         verdict = '{code: OC_WAIT, rearm: 1'b1, consume: 1'b0};
      end else if (status[ST_ERROR]) begin
         verdict = '{code: OC_FAIL, rearm: 1'b0, consume: 1'b1};
      end else if (status[ST_ACTIVE] || status[ST_IRQ]) begin
         verdict = '{code: OC_WAIT, rearm: 1'b1, consume: 1'b1};
      end else begin
         verdict = '{code: OC_RESET, rearm: 1'b0, consume: 1'b1};
      end
   end

endmodule

// File: rtl/dma_expiry_watch.sv
module dma_expiry_watch
   import dmaexp_pkg::*;
#(
   parameter int STAT_W   = 8,
   parameter int WAIT_W   = 16,
   parameter int COUNT_UP = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              done,
   input  logic [STAT_W-1:0] status,
   input  logic [WAIT_W-1:0] base_wait,
   output logic              outcome_valid,
   output logic [1:0]        outcome_code,
   output logic              error_pulse,
   output logic              reset_pulse
);

   localparam int CNT_W = WAIT_W + 1;
   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

   if (WAIT_W < 1) begin : g_bad_wait
      $error("dma_expiry_watch: WAIT_W must be positive");
   end
   if (COUNT_UP != 0 && COUNT_UP != 1) begin : g_bad_var
      $error("dma_expiry_watch: COUNT_UP must be 0 or 1");
   end

   logic [CNT_W-1:0] base_eff;
   logic [CNT_W-1:0] first_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_load;
   logic             tmr_clear;
   logic             expire;
   logic             decide;
   logic             reprieve_q;
   verdict_t         verdict;

   // R10: zero base period behaves as one
   assign base_eff   = (base_wait == '0) ? ONE_C : {1'b0, base_wait};
   assign first_load = {base_eff[CNT_W-2:0], 1'b0};

   assign decide    = expire && !start && !done;
   assign tmr_load  = start || (decide && verdict.rearm);
   assign tmr_val   = start ? first_load : base_eff;
   assign tmr_clear = done && !start;

   dmaexp_timer #(
      .CW       (CNT_W),
      .COUNT_UP (COUNT_UP)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .clear    (tmr_clear),
      .expire   (expire)
   );

   dmaexp_classify #(
      .STAT_W (STAT_W)
   ) u_classify (
      .status   (status),
      .reprieve (reprieve_q),
      .verdict  (verdict)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         reprieve_q    <= 1'b1;
         outcome_valid <= 1'b0;
         outcome_code  <= OC_IDLE;
         error_pulse   <= 1'b0;
         reset_pulse   <= 1'b0;
      end else begin
         outcome_valid <= decide;
         outcome_code  <= decide ? verdict.code : OC_IDLE;
         error_pulse   <= decide && (verdict.code == OC_FAIL);
         reset_pulse   <= decide && (verdict.code == OC_RESET);
         if (start) begin
            reprieve_q <= 1'b1;
         end else if (decide && verdict.consume) begin
            reprieve_q <= 1'b0;
         end
      end
   end

   // R8: start pre-empts a verdict at its edge
   a_r8_start_preempts: assert property (@(posedge clk) disable iff (rst)
      start |=> !outcome_valid);

   // R7: completion yields no strobe
   a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> !outcome_valid);

   // R4: spent reprieve means fail
   a_r4_spent_fails: assert property (@(posedge clk) disable iff (rst)
      (outcome_valid && !$past(reprieve_q)) |-> (outcome_code == OC_FAIL && error_pulse));

   // R9: pulses are exclusive and ride on the strobe
   a_r9_pulse_excl: assert property (@(posedge clk) disable iff (rst)
      $onehot0({error_pulse, reset_pulse}));
   a_r9_pulse_strobed: assert property (@(posedge clk) disable iff (rst)
      (error_pulse || reset_pulse) |-> outcome_valid);

   // R3: code is idle without a strobe
   a_r3_idle_code: assert property (@(posedge clk) disable iff (rst)
      !outcome_valid |-> (outcome_code == OC_IDLE));

endmodule

// File: tb/tb_dma_expiry_watch.sv
module tb_dma_expiry_watch;

   localparam int B = 4;
   localparam logic [1:0] C_IDLE = 2'd0, C_WAIT = 2'd1, C_FAIL = 2'd2, C_RST = 2'd3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        done = 1'b0;
   logic [7:0]  status = 8'h00;
   logic [15:0] base_wait = 16'(B);
   logic        outcome_valid;
   logic [1:0]  outcome_code;
   logic        error_pulse;
   logic        reset_pulse;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dma_expiry_watch dut (
      .clk           (clk),
      .rst           (rst),
      .start         (start),
      .done          (done),
      .status        (status),
      .base_wait     (base_wait),
      .outcome_valid (outcome_valid),
      .outcome_code  (outcome_code),
      .error_pulse   (error_pulse),
      .reset_pulse   (reset_pulse)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic issue;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic expect_outcome(input int gap, input logic [1:0] code, input string req);
      int k = 0;
      for (int i = 1; i <= gap + 4 && k == 0; i++) begin
         @(negedge clk);
         if (outcome_valid) k = i;
      end
      check(k == gap, {req, " strobe timing"}, k, gap);
      check(outcome_code == code, {req, " code"}, outcome_code, code);
      check(error_pulse == (code == C_FAIL), {req, " error_pulse"}, error_pulse, code == C_FAIL);
      check(reset_pulse == (code == C_RST), {req, " reset_pulse"}, reset_pulse, code == C_RST);
   endtask

   task automatic expect_quiet(input int n, input string req);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (outcome_valid || error_pulse || reset_pulse) seen++;
      end
      check(seen == 0, {req, " no strobe"}, seen, 0);
   endtask

   task automatic t_reset;
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      check(!outcome_valid && !error_pulse && !reset_pulse, "R1 reset outputs",
            {outcome_valid, error_pulse, reset_pulse}, 0);
      check(outcome_code == C_IDLE, "R1 reset code", outcome_code, C_IDLE);
   endtask

   task automatic t_error;
      status = 8'h02; issue();
      expect_outcome(2 * B, C_FAIL, "R3 R2 error bit");
      expect_quiet(3 * B, "R9 after fail");
   endtask

   task automatic t_active;
      status = 8'h01; issue();
      expect_outcome(2 * B, C_WAIT, "R3 active bit");
      expect_outcome(B, C_FAIL, "R4 R6 spent after active");
      expect_quiet(3 * B, "R4 after fail");
   endtask

   task automatic t_irq;
      status = 8'h04; issue();
      expect_outcome(2 * B, C_WAIT, "R3 irq bit");
      expect_outcome(B, C_FAIL, "R4 spent after irq");
   endtask

   task automatic t_unknown;
      status = 8'h00; issue();
      expect_outcome(2 * B, C_RST, "R3 R9 unknown status");
      expect_quiet(3 * B, "R9 after reset verdict");
   endtask

   task automatic t_priority;
      status = 8'h07; issue();
      expect_outcome(2 * B, C_FAIL, "R3 error over active");
      status = 8'h05; issue();
      expect_outcome(2 * B, C_WAIT, "R3 active with irq");
      expect_outcome(B, C_FAIL, "R4 after priority wait");
   endtask

   task automatic t_early;
      status = 8'h18; issue();
      expect_outcome(2 * B, C_WAIT, "R5 early first");
      expect_outcome(B, C_WAIT, "R5 early again");
      status = 8'h1A;
      expect_outcome(B, C_WAIT, "R5 early over error");
      status = 8'h01;
      expect_outcome(B, C_WAIT, "R5 reprieve kept");
      status = 8'h18;
      expect_outcome(B, C_FAIL, "R4 early after spent");
   endtask

   task automatic t_done_early;
      status = 8'h01; issue();
      repeat (B) @(negedge clk);
      done = 1'b1;
      @(negedge clk) done = 1'b0;
      expect_quiet(4 * B, "R7 done before expiry");
   endtask

   task automatic t_done_same;
      status = 8'h02; issue();
      repeat (2 * B - 1) @(negedge clk);
      done = 1'b1;
      @(negedge clk) done = 1'b0;
      check(!outcome_valid, "R7 done on expiry edge", outcome_valid, 0);
      expect_quiet(4 * B, "R7 done on expiry edge");
   endtask

   task automatic t_restart;
      status = 8'h01; issue();
      expect_outcome(2 * B, C_WAIT, "R8 first wait");
      issue();
      expect_outcome(2 * B, C_WAIT, "R8 reprieve restored");
      expect_outcome(B, C_FAIL, "R8 then fail");
      issue();
      repeat (3) @(negedge clk);
      issue();
      expect_outcome(2 * B, C_WAIT, "R8 mid-watch restart");
      expect_outcome(B, C_FAIL, "R8 mid-watch then fail");
   endtask

   task automatic t_zero;
      base_wait = 16'd0; status = 8'h01; issue();
      expect_outcome(2, C_WAIT, "R10 zero base first");
      expect_outcome(1, C_FAIL, "R10 zero base rearm");
      base_wait = 16'(B);
   endtask

   task automatic t_reset_mid;
      status = 8'h01; issue();
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      expect_quiet(3 * B, "R1 reset mid watch");
      issue();
      expect_outcome(2 * B, C_WAIT, "R1 reprieve after reset");
      expect_outcome(B, C_FAIL, "R1 then fail");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_error();
      t_active();
      t_irq();
      t_unknown();
      t_priority();
      t_early();
      t_done_early();
      t_done_same();
      t_restart();
      t_zero();
      t_reset_mid();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule